// File: doc/BRIEF.md
# Posted-Write Bridge to a Slow Clock Domain

This block lets a bus running on a fast CPU clock write a bank of registers that are clocked by a slow real-time clock. Each slow register has exactly one posted-write slot. An accepted write returns control to the CPU at once. The write data is then carried across the boundary by a toggle request, and the slow side answers with a toggle acknowledge. Each toggle passes through a two-flop synchronizer. When the acknowledge arrives, the slot frees and the CPU-side copy of the register is refreshed. One cycle later the copy is declared visible.

The CPU reads only that CPU-side copy, so a read never returns data that is still in flight. A per-register sync status bit reports whether the last posted write has taken visible effect. Three sticky event flags live in the CPU domain, so software clears them at once by writing ones to a mask, with no posting. They record a slot freeing up, a write becoming visible, and a write rejected because its slot was still busy. The event output is the OR of the flags, each gated by an enable bit taken from slow register 0.

Top module: `pwb_top`

## Requirements
- R1: After reset, every sync status bit is 1, all three flags are 0, the event output is 0, and every register reads 0.
- R2: A write to a register whose slot is idle is accepted. Its sync status bit reads 0 from the next cycle. It returns to 1 once the write completes, and from then on the register reads the written value.
- R3: A write to a register whose slot still holds a pending write is dropped. After completion the register holds the first value.
- R4: Every rejected write sets the error flag, bit 2 of `irq_flags`. The flag stays at 1 through any later rejections until software clears it.
- R5: When a posted write leaves its slot, the slot-free flag (bit 0 of `irq_flags`) is set.
- R6: When a posted write becomes visible, the visible flag (bit 1 of `irq_flags`) is set, or set again if already set. This happens in the same cycle that the sync status bit returns to 1.
- R7: A `clr_en` pulse clears, on the next cycle, each flag whose `clr_mask` bit is 1. Flags whose mask bit is 0 are unchanged. A new event in the same cycle wins over the clear.
- R8: `irq` is registered. It is 1 one cycle after any flag is 1 while its enable is 1. The enables are bits 0 (slot-free), 1 (visible) and 2 (error) of register 0's visible value.
- R9: While a write is pending, a read of that register returns its previous visible value and not the pending data.
- R10: Slots are independent. A pending write to one register neither blocks nor delays the acceptance of a write to another register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset, CPU domain |
| sclk | input | 1 | Slow real-time clock |
| srst | input | 1 | Synchronous active-high reset, slow domain |
| wr_en | input | 1 | Write strobe for one register |
| wr_idx | input | IDX_W | Index of the register written |
| wr_data | input | DATA_W | Write data |
| rd_idx | input | IDX_W | Index of the register read |
| rd_data | output | DATA_W | Visible value of `rd_idx`, one cycle later |
| sync_status | output | NUM_REGS | 1 = last posted write to that register is visible |
| clr_en | input | 1 | Flag clear strobe |
| clr_mask | input | 3 | Flags to clear: bit0 slot-free, bit1 visible, bit2 error |
| irq_flags | output | 3 | Sticky flags: bit0 slot-free, bit1 visible, bit2 error |
| irq | output | 1 | Enabled-flag OR, registered |

## Verification
The hardest case to reach is a second write to a register while its first write is still crossing into the slow domain. That window is open only for the few slow-clock periods of the handshake. The bench issues the second write on the very next CPU cycle after the first, so the slot is certainly busy. It also sometimes mixes in an independent write to a different register in the same window. Random data and indices then fill the bank repeatedly, and the enable bits in register 0 are changed along the way.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int FLAG_W = 3;
  typedef enum int {
    FLG_FREE = 0,
    FLG_VIS  = 1,
    FLG_ERR  = 2
  } flag_pos_e;
endpackage

// File: rtl/pwb_slot.sv
// One posted-write slot: CPU-side hold register and toggle request,
// slow-side target register and toggle acknowledge.
module pwb_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk,
  input  logic          srst,
  input  logic          wr_acc,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          synced,
  output logic          ev_free,
  output logic          ev_vis,
  output logic [DW-1:0] view
);
  // CPU domain
  logic          req_t;
  logic [DW-1:0] hold;
  logic [2:0]    ack_s;
  logic          vis_q;
  logic          ack_edge;
  // slow domain
  logic [2:0]    req_s;
  logic          ack_t;
  logic [DW-1:0] sreg;

  assign ack_edge = ack_s[2] ^ ack_s[1];
  assign ev_free  = ack_edge;
  assign ev_vis   = vis_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      synced <= 1'b1;
      req_t  <= 1'b0;
      hold   <= '0;
      ack_s  <= '0;
      vis_q  <= 1'b0;
      view   <= '0;
    end else begin
      ack_s <= {ack_s[1:0], ack_t};
      vis_q <= ack_edge;
      if (ack_edge) view <= sreg;   // sreg is stable until the next request
      if (wr_acc) begin
        busy   <= 1'b1;
        req_t  <= ~req_t;
        hold   <= wr_data;
        synced <= 1'b0;
      end else begin
        if (ack_edge) busy   <= 1'b0;
        if (vis_q)    synced <= 1'b1;
      end
    end
  end

  always_ff @(posedge sclk) begin
    if (srst) begin
      req_s <= '0;
      ack_t <= 1'b0;
      sreg  <= '0;
    end else begin
      req_s <= {req_s[1:0], req_t};
      if (req_s[2] ^ req_s[1]) begin
        sreg  <= hold;               // hold is stable while busy
        ack_t <= ~ack_t;
      end
    end
  end
endmodule

// File: rtl/pwb_irq.sv
// Sticky event flags in the CPU domain, immediate write-1 clear, gated OR.
module pwb_irq
  import pwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] set_ev,
  input  logic              clr_en,
  input  logic [FLAG_W-1:0] clr_mask,
  input  logic [FLAG_W-1:0] enable,
  output logic [FLAG_W-1:0] flags,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      for (int k = 0; k < FLAG_W; k++)
        flags[k] <= set_ev[k] | (flags[k] & ~(clr_en & clr_mask[k]));
      irq <= |(flags & enable);
    end
  end
endmodule

// File: rtl/pwb_top.sv
module pwb_top
  import pwb_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              srst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_REGS-1:0] sync_status,
  input  logic              clr_en,
  input  logic [FLAG_W-1:0] clr_mask,
  output logic [FLAG_W-1:0] irq_flags,
  output logic              irq
);
  logic [NUM_REGS-1:0] wr_acc, wr_rej, slot_busy, ev_free, ev_vis;
  logic [DATA_W-1:0]   view [NUM_REGS];
  logic [FLAG_W-1:0]   set_ev, irq_en;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    logic hit;
    assign hit       = wr_en && (wr_idx == IDX_W'(i));
    assign wr_acc[i] = hit && !slot_busy[i];
    assign wr_rej[i] = hit &&  slot_busy[i];

    pwb_slot #(.DW(DATA_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .sclk    (sclk),
      .srst    (srst),
      .wr_acc  (wr_acc[i]),
      .wr_data (wr_data),
      .busy    (slot_busy[i]),
      .synced  (sync_status[i]),
      .ev_free (ev_free[i]),
      .ev_vis  (ev_vis[i]),
      .view    (view[i])
    );
  end

  assign set_ev[FLG_FREE] = |ev_free;
  assign set_ev[FLG_VIS]  = |ev_vis;
  assign set_ev[FLG_ERR]  = |wr_rej;
  assign irq_en           = view[0][FLAG_W-1:0];

  pwb_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .set_ev   (set_ev),
    .clr_en   (clr_en),
    .clr_mask (clr_mask),
    .enable   (irq_en),
    .flags    (irq_flags),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= view[rd_idx];
  end
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] wr_acc,
  input logic [N-1:0] wr_rej,
  input logic [N-1:0] slot_busy,
  input logic [N-1:0] sync_status,
  input logic [N-1:0] ev_free,
  input logic [N-1:0] ev_vis,
  input logic         clr_en,
  input logic [2:0]   clr_mask,
  input logic [2:0]   irq_flags,
  input logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_a
    assert_accept_clears_sync_R2: assert property (@(posedge clk) disable iff (rst)
      wr_acc[i] |=> !sync_status[i]);
    assert_busy_not_visible_R2: assert property (@(posedge clk) disable iff (rst)
      slot_busy[i] |-> !sync_status[i]);
  end

  assert_reject_sets_err_R4: assert property (@(posedge clk) disable iff (rst)
    (|wr_rej) |=> irq_flags[2]);
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (irq_flags[2] && !(clr_en && clr_mask[2])) |=> irq_flags[2]);
  assert_free_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (|ev_free) |=> irq_flags[0]);
  assert_visible_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (|ev_vis) |=> irq_flags[1]);
  assert_clear_works_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_en && clr_mask[0] && !(|ev_free)) |=> !irq_flags[0]);
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_flags == 3'b000) |=> !irq);
endmodule

bind pwb_top pwb_chk #(.N(NUM_REGS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_acc      (wr_acc),
  .wr_rej      (wr_rej),
  .slot_busy   (slot_busy),
  .sync_status (sync_status),
  .ev_free     (ev_free),
  .ev_vis      (ev_vis),
  .clr_en      (clr_en),
  .clr_mask    (clr_mask),
  .irq_flags   (irq_flags),
  .irq         (irq)
);

// File: tb/sim_pwb_top.sv
`timescale 1ns/1ps
module sim_pwb_top;
  localparam int NR = 4;
  localparam int DW = 16;

  logic clk = 0, sclk = 0, rst = 1, srst = 1;
  logic wr_en = 0, clr_en = 0;
  logic [1:0] wr_idx = 0, rd_idx = 0;
  logic [DW-1:0] wr_data = 0;
  logic [2:0] clr_mask = 0;
  logic [DW-1:0] rd_data;
  logic [NR-1:0] sync_status;
  logic [2:0] irq_flags;
  logic irq;

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_val [NR];

  always #2 clk = ~clk;     // 250 MHz
  always #20 sclk = ~sclk;

  pwb_top #(.NUM_REGS(NR), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .srst(srst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .sync_status(sync_status),
    .clr_en(clr_en), .clr_mask(clr_mask), .irq_flags(irq_flags), .irq(irq)
  );

  function automatic logic exp_irq(logic [2:0] f, logic [DW-1:0] r0);
    return |(f & r0[2:0]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_write(int idx, logic [DW-1:0] d);
    wr_en = 1; wr_idx = idx[1:0]; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic do_read(int idx, output logic [DW-1:0] v);
    rd_idx = idx[1:0];
    tick();
    v = rd_data;
  endtask

  task automatic do_clear(logic [2:0] m);
    clr_en = 1; clr_mask = m;
    tick();
    clr_en = 0; clr_mask = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (sync_status !== {NR{1'b1}} && n < 400) begin tick(); n++; end
    if (n >= 400) chk("R2 completion timeout", sync_status, {NR{1'b1}});
    tick(); tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd7));
    for (int i = 0; i < NR; i++) exp_val[i] = '0;
    repeat (30) tick();
    rst = 0; srst = 0;
    tick();

    // R1 reset state
    chk("R1 sync", sync_status, 4'hF);
    chk("R1 flags", irq_flags, 0);
    chk("R1 irq", irq, 0);
    for (int i = 0; i < NR; i++) begin do_read(i, v); chk("R1 read", v, 0); end

    // R2/R3/R4/R9/R10 directed
    do_write(1, 16'h1234);
    chk("R2 sync low", sync_status[1], 0);
    do_write(1, 16'hBEEF);
    chk("R4 err set", irq_flags[2], 1);
    do_write(2, 16'h0055);
    chk("R10 other accepted", sync_status[2], 0);
    do_read(1, v);
    chk("R9 old value", v, 0);
    wait_idle();
    do_read(1, v); chk("R3 first kept", v, 16'h1234);
    do_read(2, v); chk("R10 value", v, 16'h0055);
    chk("R5 free flag", irq_flags[0], 1);
    chk("R6 visible flag", irq_flags[1], 1);
    chk("R8 no enables", irq, 0);
    exp_val[1] = 16'h1234; exp_val[2] = 16'h0055;

    do_write(3, 16'h0A0A);
    do_write(3, 16'h0B0B);
    chk("R4 sticky", irq_flags[2], 1);
    wait_idle();
    exp_val[3] = 16'h0A0A;

    // R7 clearing
    do_clear(3'b100);
    chk("R7 clear err", irq_flags, 3'b011);
    do_clear(3'b000);
    chk("R7 zero mask", irq_flags, 3'b011);
    do_clear(3'b011);
    chk("R7 clear rest", irq_flags, 3'b000);

    // R8 enable gating via register 0
    do_write(0, 16'h0002);
    wait_idle();
    exp_val[0] = 16'h0002;
    chk("R8 visible enabled", irq, 1);
    do_clear(3'b010);
    tick();
    chk("R8 free not enabled", irq, 0);
    do_write(0, 16'h0007);
    wait_idle();
    exp_val[0] = 16'h0007;
    chk("R8 all enabled", irq, 1);
    do_clear(3'b111);
    tick();
    chk("R8 cleared", irq, 0);

    // random mix
    for (int it = 0; it < 60; it++) begin
      int idx = $urandom_range(0, NR-1);
      logic [DW-1:0] d  = DW'($urandom);
      logic [DW-1:0] d2 = DW'($urandom);
      logic other = $urandom_range(0, 1);
      int oidx = (idx + 1) % NR;
      logic [DW-1:0] od = DW'($urandom);
      do_write(idx, d);
      chk("R2 random sync low", sync_status[idx], 0);
      exp_val[idx] = d;
      if ($urandom_range(0, 1) == 1) begin
        do_write(idx, d2);
        chk("R4 random reject", irq_flags[2], 1);
      end
      if (other) begin
        do_write(oidx, od);
        exp_val[oidx] = od;
      end
      wait_idle();
      do_read(idx, v); chk("R3 random value", v, exp_val[idx]);
      if (other) begin do_read(oidx, v); chk("R10 random other", v, exp_val[oidx]); end
      chk("R6 random visible", irq_flags[1], 1);
      chk("R8 random irq", irq, exp_irq(irq_flags, exp_val[0]));
      if ($urandom_range(0, 3) == 0) begin
        do_clear(3'b111);
        chk("R7 random clear", irq_flags, 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule